// File: doc/BRIEF.md
# LIN Break Field Detector

This block watches a LIN serial receive line for a break field and raises a sticky flag when one has ended. It runs on its own, alongside whatever character receiver shares the line, and uses none of that receiver's framing. A break is a dominant (logic 0) stretch of more than `BREAK_BITS` bit times that is closed by a recessive (logic 1) level. The line is sampled on an oversampling tick (`OVERSAMPLE` ticks per bit), so the required dominant time is `(BREAK_BITS+1)*OVERSAMPLE` ticks.

The receive input is first retimed through a flop chain. Each tick then either extends a saturating dominant-time count or, on a recessive sample, ends the run. The flag is set only when a recessive sample ends a run that met the threshold. Software clears the flag with a one-cycle pulse. An interrupt request follows the flag whenever the interrupt enable is high.

Top module: `lin_break_detector`

## Requirements
- R1: After reset, `brk_flag` and `brk_irq` are 0.
- R2: While `det_en` is 0, the dominant count is held at zero and no break is detected. Dominant time seen while disabled does not add to a run that goes on after enabling.
- R3: `rx_i` passes through `SYNC_STAGES` flops (default 2) before it is sampled. A tick (`os_tick` = 1) that sees a recessive (1) level after at least `(BREAK_BITS+1)*OVERSAMPLE` consecutive dominant (0) ticks sets `brk_flag` at that same clock edge.
- R4: A recessive tick that ends a dominant run shorter than the threshold restarts the count from zero and leaves `brk_flag` unchanged.
- R5: While the line stays dominant, `brk_flag` does not rise, even after the threshold is passed. It rises only on the recessive delimiter tick.
- R6: Once set, `brk_flag` stays 1 through any line activity until a cycle with `flag_clr` = 1, after which it reads 0.
- R7: When `flag_clr` and a detection fall in the same cycle, `brk_flag` is 1 afterwards.
- R8: `brk_irq` is 1 exactly when `brk_flag` is 1 and `irq_en` is 1, in the same cycle.
- R9: The dominant count saturates at its maximum and does not wrap, so a dominant run far longer than the threshold is still detected at its recessive end.
- R10: The count changes only on cycles with `os_tick` = 1. Line levels between ticks are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| det_en | input | 1 | Detection enable |
| rx_i | input | 1 | Serial receive line, 0 = dominant |
| os_tick | input | 1 | Oversampling tick, one cycle wide |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle clear pulse for the flag |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OVERSAMPLE` = 4 and `BREAK_BITS` = 11. This gives a 48-tick threshold and a 7-bit count, so a 47/48-tick edge pair and a 130-tick run are short to drive. The 130-tick run passes the count's wrap point, where a wrapping counter would land at 2 and miss the break. Ticks are spaced three clocks apart, so the two-flop retiming lag and the clear-versus-detect collision fall on exactly known ticks.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic {
    LVL_DOM = 1'b0,
    LVL_REC = 1'b1
  } line_lvl_e;

  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_HOLD  = 2'd1,
    CNT_INC   = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/lin_brk_rst_sync.sv
module lin_brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lin_brk_rx_sync.sv
module lin_brk_rx_sync
  import lin_brk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_async,
  output line_lvl_e rx_lvl
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = rx_async;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= LVL_REC;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign rx_lvl = line_lvl_e'(stage_q[STAGES-1]);

endmodule

// File: rtl/lin_brk_dom_counter.sv
module lin_brk_dom_counter
  import lin_brk_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int THRESH = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             os_tick,
  input  line_lvl_e        rx_lvl,
  output logic [CNT_W-1:0] dom_cnt,
  output logic             delim_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR_V   = CNT_W'(THRESH);

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             run_ok;

  // Decide what the count does this cycle.
  always_comb begin
    if (!det_en) begin
      op = CNT_CLEAR;
    end else if (!os_tick) begin
      op = CNT_HOLD;
    end else if (rx_lvl == LVL_DOM) begin
      op = CNT_INC;
    end else begin
      op = CNT_CLEAR;
    end
  end

  always_comb begin
    run_ok = (cnt_q >= THR_V);
    cnt_en = (op != CNT_HOLD);
    unique case (op)
      CNT_INC:   cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      CNT_CLEAR: cnt_d = '0;
      default:   cnt_d = cnt_q;
    endcase
    delim_hit = det_en && os_tick && (rx_lvl == LVL_REC) && run_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign dom_cnt = cnt_q;

endmodule

// File: rtl/lin_brk_flag.sv
module lin_brk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic delim_hit,
  input  logic flag_clr,
  input  logic irq_en,
  output logic brk_flag,
  output logic brk_irq
);

  logic flag_q;
  logic flag_d;
  logic flag_we;

  // Set wins over clear.
  always_comb begin
    flag_we = delim_hit || flag_clr;
    flag_d  = delim_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_we) begin
      flag_q <= flag_d;
    end
  end

  assign brk_flag = flag_q;
  assign brk_irq  = flag_q & irq_en;

endmodule

// File: rtl/lin_break_detector.sv
module lin_break_detector
  import lin_brk_pkg::*;
#(
  parameter int OVERSAMPLE   = 16,
  parameter int BREAK_BITS   = 11,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_en,
  input  logic rx_i,
  input  logic os_tick,
  input  logic irq_en,
  input  logic flag_clr,
  output logic brk_flag,
  output logic brk_irq
);

  localparam int THRESH = (BREAK_BITS + 1) * OVERSAMPLE;
  localparam int CNT_W  = $clog2(THRESH) + 1;

  logic             rst_n_int;
  line_lvl_e        rx_lvl;
  logic [CNT_W-1:0] dom_cnt;
  logic             delim_hit;

  lin_brk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lin_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rx_async (rx_i),
    .rx_lvl   (rx_lvl)
  );

  lin_brk_dom_counter #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .det_en    (det_en),
    .os_tick   (os_tick),
    .rx_lvl    (rx_lvl),
    .dom_cnt   (dom_cnt),
    .delim_hit (delim_hit)
  );

  lin_brk_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .delim_hit (delim_hit),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .brk_flag  (brk_flag),
    .brk_irq   (brk_irq)
  );

endmodule

// File: rtl/lin_break_detector_chk.sv
module lin_break_detector_chk #(
  parameter int CNT_W  = 9,
  parameter int THRESH = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             os_tick,
  input logic             irq_en,
  input logic             flag_clr,
  input logic             brk_flag,
  input logic             brk_irq,
  input logic             rx_s,
  input logic [CNT_W-1:0] dom_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR_V   = CNT_W'(THRESH);

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!brk_flag && !brk_irq);
    end
  end

  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> dom_cnt == '0);

  assert_rise_long_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(dom_cnt) >= THR_V);

  assert_rise_on_delim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(rx_s) && $past(os_tick) && $past(det_en));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !flag_clr |=> brk_flag);

  assert_fall_by_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_flag) |-> $past(flag_clr));

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_flag && irq_en);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dom_cnt == CNT_MAX && det_en && !rx_s |=> dom_cnt == CNT_MAX || !$past(det_en));

  assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    det_en && !os_tick |=> $stable(dom_cnt));

endmodule

bind lin_break_detector lin_break_detector_chk #(
  .CNT_W  (CNT_W),
  .THRESH (THRESH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .det_en   (det_en),
  .os_tick  (os_tick),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .brk_flag (brk_flag),
  .brk_irq  (brk_irq),
  .rx_s     (rx_lvl),
  .dom_cnt  (dom_cnt)
);

// File: tb/lin_break_detector_tb_top.sv
`timescale 1ns/1ps
module lin_break_detector_tb_top;

  localparam int OS     = 4;
  localparam int BB     = 11;
  localparam int THR    = (BB + 1) * OS;
  localparam int GAP    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_en = 1'b0;
  logic rx_i = 1'b1;
  logic os_tick = 1'b0;
  logic irq_en = 1'b0;
  logic flag_clr = 1'b0;
  logic brk_flag;
  logic brk_irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lin_break_detector #(.OVERSAMPLE(OS), .BREAK_BITS(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .rx_i(rx_i),
    .os_tick(os_tick), .irq_en(irq_en), .flag_clr(flag_clr),
    .brk_flag(brk_flag), .brk_irq(brk_irq)
  );

  // Behavioural reference model
  bit q_line[$];
  int m_run;
  bit m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_line = {1'b1, 1'b1};
      m_run  = 0;
      m_flag = 1'b0;
    end else begin
      bit seen;
      bit hit;
      seen = q_line.pop_front();
      q_line.push_back(rx_i);
      hit = 1'b0;
      if (!det_en) m_run = 0;
      else if (os_tick) begin
        if (!seen) m_run = m_run + 1;
        else begin
          hit = (m_run >= THR);
          m_run = 0;
        end
      end
      if (hit) m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, brk_flag, m_flag, "brk_flag vs model");
      check("R8", brk_irq, m_flag && irq_en, "brk_irq vs model");
    end
  end

  task automatic ticks(input int n, input logic lvl, input bit clr_on_tick);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_i = lvl; os_tick = 1'b1; flag_clr = clr_on_tick;
      @(negedge clk);
      os_tick = 1'b0; flag_clr = 1'b0;
      for (int j = 1; j < GAP; j++) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", brk_flag, 1'b0, "flag in reset");
    check("R1", brk_irq, 1'b0, "irq in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check("R1", brk_flag, 1'b0, "flag after reset");

    // R2: disabled, then dominant time must not carry over
    cur_req = "R2";
    ticks(60, 1'b0, 1'b0);
    ticks(3, 1'b1, 1'b0);
    check("R2", brk_flag, 1'b0, "no detect while disabled");
    ticks(40, 1'b0, 1'b0);
    @(negedge clk); det_en = 1'b1;
    ticks(10, 1'b0, 1'b0);
    ticks(3, 1'b1, 1'b0);
    check("R2", brk_flag, 1'b0, "disabled time not counted");

    // R4: short runs
    cur_req = "R4";
    ticks(THR - 1, 1'b0, 1'b0);
    ticks(2, 1'b1, 1'b0);
    check("R4", brk_flag, 1'b0, "47 ticks no detect");
    ticks(THR - 1, 1'b0, 1'b0);
    ticks(1, 1'b1, 1'b0);
    ticks(THR - 1, 1'b0, 1'b0);
    ticks(2, 1'b1, 1'b0);
    check("R4", brk_flag, 1'b0, "split run restarts");

    // R5 / R3: threshold passed while dominant, flag only on delimiter
    cur_req = "R5";
    ticks(THR + 20, 1'b0, 1'b0);
    check("R5", brk_flag, 1'b0, "no flag while dominant");
    cur_req = "R3";
    ticks(1, 1'b1, 1'b0);
    check("R3", brk_flag, 1'b0, "lag tick still counts dominant");
    ticks(1, 1'b1, 1'b0);
    check("R3", brk_flag, 1'b1, "flag on delimiter");

    // R6: sticky, then clear
    cur_req = "R6";
    ticks(THR - 5, 1'b0, 1'b0);
    ticks(3, 1'b1, 1'b0);
    check("R6", brk_flag, 1'b1, "sticky through activity");
    irq_en = 1'b1;
    idle(2);
    check("R8", brk_irq, 1'b1, "irq with flag and enable");
    clear_pulse();
    idle(1);
    check("R6", brk_flag, 1'b0, "cleared by pulse");
    check("R8", brk_irq, 1'b0, "irq drops with flag");

    // R3 minimum length exactly at threshold
    cur_req = "R3";
    ticks(THR, 1'b0, 1'b0);
    ticks(2, 1'b1, 1'b0);
    check("R3", brk_flag, 1'b1, "48 ticks detects");
    @(negedge clk); irq_en = 1'b0;
    idle(1);
    check("R8", brk_irq, 1'b0, "irq masked");
    clear_pulse();

    // R7: clear coincides with the detecting tick
    cur_req = "R7";
    ticks(THR + 2, 1'b0, 1'b0);
    ticks(2, 1'b1, 1'b1);
    check("R7", brk_flag, 1'b1, "detect beats clear");
    clear_pulse();
    idle(1);
    check("R7", brk_flag, 1'b0, "clear afterwards");

    // R9: long run past the counter's wrap point
    cur_req = "R9";
    ticks(130, 1'b0, 1'b0);
    ticks(2, 1'b1, 1'b0);
    check("R9", brk_flag, 1'b1, "130-tick run detected");
    clear_pulse();

    // R10: dominant line with no ticks does not count
    cur_req = "R10";
    @(negedge clk); rx_i = 1'b0;
    idle(300);
    ticks(3, 1'b1, 1'b0);
    check("R10", brk_flag, 1'b0, "no tick no count");

    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule